// File: doc/BRIEF.md
# Per-Source Trigger Interrupt Controller

This block gathers up to 32 asynchronous interrupt lines. Each line is brought into the clock domain through its own synchronizer. Each line then follows a trigger mode of its own: a rising edge, a falling edge, either edge, a high level or a low level. Edges are held in two capture registers, one for rising events and one for falling events, until software acknowledges them. A per-source mask gates every line. A per-source routing bit then steers it to one of two request outputs. A separate per-source enable feeds a wake output.

Software reaches every control register through three addresses: one to read, one to set and one to clear. A 1 in the written word changes the matching bit and a 0 leaves it alone, so a driver can change one source without a read-modify-write. The request outputs and the wake output are plain combinational levels taken from registered state. There is no data stream at the edge of the block, so the bus is a plain single-cycle write port with a combinational read port.

Top module: `trig_irq_ctrl`

## Requirements
- R1: The address is split into a register id in bits [5:2] and an operation in bits [1:0]: 0 means read, 1 means set, 2 means clear. The register ids are: 0 mode bit A, 1 mode bit B, 2 mode bit C, 3 source select, 4 route, 5 wake enable, 6 mask. A write sets or clears exactly the bits written as 1, and the register reads back its new value on the next cycle.
- R2: After reset, every register reads 0 except the route register, which reads all ones. The outputs req0, req1 and wake are low.
- R3: With mode C:B:A = 001 (rising), a 0-to-1 change on a line sets its bit in the rising capture register (id 7), and the source becomes active.
- R4: With mode 010 (falling), a 1-to-0 change sets the falling capture register (id 8). With mode 011, both edges are captured. With mode 000, or with C = 1, no edge is captured.
- R5: A write of 1 at the clear address of a capture register (id 7 or 8, operation 2) clears that capture bit. Set writes to capture registers are ignored.
- R6: With mode 101 a source is active while its synchronized line is high. With mode 110 it is active while the line is low. Modes 100 and 111 are never active, and level modes ignore the capture bits.
- R7: A source reaches a request output only while its mask bit is 1. Clearing the mask bit drops the request on the cycle the write takes effect.
- R8: A masked, active source with its route bit 1 shows in pending register 0 (id 9) and drives req0. With its route bit 0 it shows in pending register 1 (id 10) and drives req1. Each request output is the OR of its pending register.
- R9: wake is high when any active source has its wake-enable bit set, whatever its mask bit.
- R10: The test register (id 11) always reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Asynchronous interrupt lines |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 6 | Write address: register id and operation |
| wr_data | input | 32 | Bit pattern to set or clear |
| rd_addr | input | 6 | Read address; the operation bits are ignored |
| rd_data | output | 32 | Combinational read data |
| req0 | output | 1 | Request output 0 |
| req1 | output | 1 | Request output 1 |
| wake | output | 1 | Wake output |

## Verification
The bench aims at the mode codes that are easy to decode loosely. If 100 and 111 were treated as levels, requests would appear that nothing asked for. If captures were armed while a source is in level mode, a stale event would survive a switch back to edge mode. It also checks that clearing a mask removes the request in the very next cycle. A design that registered the request path would show one extra cycle of request. Random set and clear patterns expose any design that lets zero bits disturb state, or that lets a set write reach a capture register.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;
  localparam int ID_W     = 4;
  localparam int OP_W     = 2;
  localparam int NUM_CTRL = 7;

  typedef enum logic [ID_W-1:0] {
    RID_MODE_A = 4'd0,
    RID_MODE_B = 4'd1,
    RID_MODE_C = 4'd2,
    RID_SRCSEL = 4'd3,
    RID_ROUTE  = 4'd4,
    RID_WAKEEN = 4'd5,
    RID_MASK   = 4'd6,
    RID_RISE   = 4'd7,
    RID_FALL   = 4'd8,
    RID_PEND0  = 4'd9,
    RID_PEND1  = 4'd10,
    RID_TEST   = 4'd11
  } reg_id_e;

  typedef enum logic [OP_W-1:0] {
    OP_READ = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } reg_op_e;
endpackage

// File: rtl/tirq_sync.sv
module tirq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise_p,
  output logic [W-1:0] fall_p
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= stage_q[STAGES-1];
  end

  assign level  = stage_q[STAGES-1];
  assign rise_p = stage_q[STAGES-1] & ~prev_q;
  assign fall_p = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tirq_setclr_reg.sv
module tirq_setclr_reg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else if (set_we) q <= q | bits;
    else if (clr_we) q <= q & ~bits;
  end
endmodule

// File: rtl/tirq_capture.sv
module tirq_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_p,
  input  logic [W-1:0] fall_p,
  input  logic [W-1:0] mode_a,
  input  logic [W-1:0] mode_b,
  input  logic [W-1:0] mode_c,
  input  logic         clr_rise_we,
  input  logic         clr_fall_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] rise_cap,
  output logic [W-1:0] fall_cap,
  output logic [W-1:0] active
);
  logic [W-1:0] rise_arm, fall_arm;
  assign rise_arm = ~mode_c & mode_a;
  assign fall_arm = ~mode_c & mode_b;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_src
      // a new event wins over an acknowledge in the same cycle
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rise_cap[i] <= 1'b0;
          fall_cap[i] <= 1'b0;
        end else begin
          if (rise_p[i] && rise_arm[i]) rise_cap[i] <= 1'b1;
          else if (clr_rise_we && clr_bits[i]) rise_cap[i] <= 1'b0;
          if (fall_p[i] && fall_arm[i]) fall_cap[i] <= 1'b1;
          else if (clr_fall_we && clr_bits[i]) fall_cap[i] <= 1'b0;
        end
      end

      always_comb begin
        unique case ({mode_c[i], mode_b[i], mode_a[i]})
          3'b001, 3'b010, 3'b011:
            active[i] = (rise_cap[i] & mode_a[i]) | (fall_cap[i] & mode_b[i]);
          3'b101:  active[i] = level[i];
          3'b110:  active[i] = ~level[i];
          default: active[i] = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
  import trig_irq_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NSRC-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NSRC-1:0]   rd_data,
  output logic              req0,
  output logic              req1,
  output logic              wake
);
  localparam int ID_LSB = OP_W;

  logic [ID_W-1:0] wr_id, rd_id;
  logic [OP_W-1:0] wr_op;
  assign wr_id = wr_addr[ID_LSB +: ID_W];
  assign wr_op = wr_addr[OP_W-1:0];
  assign rd_id = rd_addr[ID_LSB +: ID_W];

  logic [NSRC-1:0] ctrl_q [NUM_CTRL];

  genvar k;
  generate
    for (k = 0; k < NUM_CTRL; k++) begin : g_ctrl
      localparam logic [NSRC-1:0] RV = (k == int'(RID_ROUTE)) ? {NSRC{1'b1}} : {NSRC{1'b0}};
      logic set_we, clr_we;
      assign set_we = wr_en && (wr_id == ID_W'(k)) && (wr_op == OP_SET);
      assign clr_we = wr_en && (wr_id == ID_W'(k)) && (wr_op == OP_CLR);
      tirq_setclr_reg #(.W(NSRC), .RST_VAL(RV)) u_reg (
        .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
        .bits(wr_data), .q(ctrl_q[k])
      );
    end
  endgenerate

  logic [NSRC-1:0] mode_a_q, mode_b_q, mode_c_q, srcsel_q, route_q, wake_q, mask_q;
  assign mode_a_q = ctrl_q[RID_MODE_A];
  assign mode_b_q = ctrl_q[RID_MODE_B];
  assign mode_c_q = ctrl_q[RID_MODE_C];
  assign srcsel_q = ctrl_q[RID_SRCSEL];
  assign route_q  = ctrl_q[RID_ROUTE];
  assign wake_q   = ctrl_q[RID_WAKEEN];
  assign mask_q   = ctrl_q[RID_MASK];

  logic [NSRC-1:0] lvl, rise_p, fall_p;
  tirq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_in),
    .level(lvl), .rise_p(rise_p), .fall_p(fall_p)
  );

  logic clr_rise_we, clr_fall_we;
  assign clr_rise_we = wr_en && (wr_id == RID_RISE) && (wr_op == OP_CLR);
  assign clr_fall_we = wr_en && (wr_id == RID_FALL) && (wr_op == OP_CLR);

  logic [NSRC-1:0] rise_cap, fall_cap, active;
  tirq_capture #(.W(NSRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .level(lvl), .rise_p(rise_p), .fall_p(fall_p),
    .mode_a(mode_a_q), .mode_b(mode_b_q), .mode_c(mode_c_q),
    .clr_rise_we(clr_rise_we), .clr_fall_we(clr_fall_we), .clr_bits(wr_data),
    .rise_cap(rise_cap), .fall_cap(fall_cap), .active(active)
  );

  logic [NSRC-1:0] pend0, pend1;
  assign pend0 = active & mask_q & route_q;
  assign pend1 = active & mask_q & ~route_q;
  assign req0  = |pend0;
  assign req1  = |pend1;
  assign wake  = |(active & wake_q);

  always_comb begin
    case (rd_id)
      RID_MODE_A: rd_data = mode_a_q;
      RID_MODE_B: rd_data = mode_b_q;
      RID_MODE_C: rd_data = mode_c_q;
      RID_SRCSEL: rd_data = srcsel_q;
      RID_ROUTE:  rd_data = route_q;
      RID_WAKEEN: rd_data = wake_q;
      RID_MASK:   rd_data = mask_q;
      RID_RISE:   rd_data = rise_cap;
      RID_FALL:   rd_data = fall_cap;
      RID_PEND0:  rd_data = pend0;
      RID_PEND1:  rd_data = pend1;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tirq_checker.sv
module tirq_checker #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NSRC-1:0]   wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [NSRC-1:0]   rd_data,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   mode_c_q,
  input logic [NSRC-1:0]   rise_cap,
  input logic [NSRC-1:0]   pend0,
  input logic [NSRC-1:0]   pend1,
  input logic [NSRC-1:0]   wake_q,
  input logic              wake
);
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 6'd25) |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R1
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 6'd26) |=> ((mask_q & $past(wr_data)) == '0)); // R7
  AST_NO_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_cap & ~$past(rise_cap) & $past(mode_c_q)) == '0)); // R4
  AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 & pend1) == '0); // R8
  AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend0 | pend1) & ~mask_q) == '0); // R7
  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (wake_q != '0)); // R9
  AST_TEST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[5:2] == 4'd11) |-> (rd_data == '0)); // R10
endmodule

bind trig_irq_ctrl tirq_checker #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .mask_q(mask_q), .mode_c_q(mode_c_q),
  .rise_cap(rise_cap), .pend0(pend0), .pend1(pend1), .wake_q(wake_q), .wake(wake)
);

// File: tb/sim_trig_irq_ctrl.sv
`timescale 1ns/1ps
module sim_trig_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        req0, req1, wake;

  always #2 clk = ~clk;

  trig_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .req0(req0), .req1(req1), .wake(wake)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state: 0..6 control registers
  logic [31:0] m_ctrl [7];
  logic [31:0] m_rise, m_fall, m_in;

  function automatic logic [31:0] m_active();
    logic [31:0] a;
    for (int i = 0; i < 32; i++) begin
      case ({m_ctrl[2][i], m_ctrl[1][i], m_ctrl[0][i]})
        3'b001, 3'b010, 3'b011: a[i] = (m_rise[i] & m_ctrl[0][i]) | (m_fall[i] & m_ctrl[1][i]);
        3'b101: a[i] = m_in[i];
        3'b110: a[i] = ~m_in[i];
        default: a[i] = 1'b0;
      endcase
    end
    return a;
  endfunction

  function automatic logic [31:0] m_read(int id);
    case (id)
      0, 1, 2, 3, 4, 5, 6: return m_ctrl[id];
      7:  return m_rise;
      8:  return m_fall;
      9:  return m_active() & m_ctrl[6] & m_ctrl[4];
      10: return m_active() & m_ctrl[6] & ~m_ctrl[4];
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    logic [31:0] p0, p1;
    for (int id = 0; id < 12; id++) begin
      rd_addr = 6'(id << 2);
      #0.1;
      chk(tag, $sformatf("reg%0d", id), rd_data, m_read(id));
    end
    p0 = m_read(9);
    p1 = m_read(10);
    chk(tag, "req0", {31'b0, req0}, {31'b0, |p0});
    chk(tag, "req1", {31'b0, req1}, {31'b0, |p1});
    chk(tag, "wake", {31'b0, wake}, {31'b0, |(m_active() & m_ctrl[5])});
  endtask

  task automatic do_write(int id, int op, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'((id << 2) | op); wr_data = d;
    @(posedge clk);
    #0.5;
    wr_en = 1'b0;
    if (id < 7 && op == 1) m_ctrl[id] = m_ctrl[id] | d;
    else if (id < 7 && op == 2) m_ctrl[id] = m_ctrl[id] & ~d;
    else if (id == 7 && op == 2) m_rise = m_rise & ~d;
    else if (id == 8 && op == 2) m_fall = m_fall & ~d;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_in(logic [31:0] v);
    logic [31:0] up, dn;
    @(negedge clk);
    irq_in = v;
    up = v & ~m_in;
    dn = ~v & m_in;
    m_rise = m_rise | (up & ~m_ctrl[2] & m_ctrl[0]);
    m_fall = m_fall | (dn & ~m_ctrl[2] & m_ctrl[1]);
    m_in = v;
    settle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 7; k++) m_ctrl[k] = (k == 4) ? '1 : '0;
    m_rise = '0; m_fall = '0; m_in = '0;
    repeat (4) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    compare_all("R2");

    // R3: rising edge on source 1 routed to req0
    do_write(0, 1, 32'h2);
    do_write(6, 1, 32'h2);
    drive_in(32'h2);
    compare_all("R3");
    // R5: acknowledge rising capture; set write to capture is ignored
    do_write(7, 2, 32'h2);
    settle();
    compare_all("R5");
    do_write(7, 1, 32'hffff_ffff);
    settle();
    compare_all("R5");

    // R4: falling on source 2, both on source 1
    do_write(1, 1, 32'h6);
    do_write(6, 1, 32'h4);
    drive_in(32'h6);
    compare_all("R4");
    drive_in(32'h0);
    compare_all("R4");
    do_write(8, 2, 32'h6);
    settle();
    compare_all("R4");

    // R6: source 4 low level on req1, source 5 high level, source 6 mode 111
    do_write(2, 1, 32'h70);
    do_write(1, 1, 32'h50);
    do_write(0, 1, 32'h60);
    do_write(4, 2, 32'h10);
    do_write(6, 1, 32'h70);
    settle();
    compare_all("R6");
    drive_in(32'h70);
    compare_all("R6");
    // R8: routing of source 5 to req1
    do_write(4, 2, 32'h20);
    settle();
    compare_all("R8");

    // R7: mask clear drops the request in the cycle the write lands
    do_write(6, 2, 32'h20);
    chk("R7", "req1 after mask clear", {31'b0, req1}, {31'b0, |m_read(10)});
    settle();
    compare_all("R7");

    // R9: wake follows active sources with wake enable, regardless of mask
    do_write(5, 1, 32'h20);
    settle();
    compare_all("R9");

    // R10: test register ignores writes
    do_write(11, 1, 32'hffff_ffff);
    do_write(11, 2, 32'h1234_5678);
    settle();
    compare_all("R10");

    // R1: constrained random mix of set/clear writes and line changes
    for (int it = 0; it < 300; it++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 6) begin
        int id, op;
        logic [31:0] d;
        id = $urandom_range(0, 11);
        op = $urandom_range(1, 2);
        d  = $urandom();
        if ($urandom_range(0, 3) == 0) d = d & $urandom();
        do_write(id, op, d);
      end else begin
        logic [31:0] v;
        v = m_in ^ ($urandom() & $urandom());
        drive_in(v);
        continue;
      end
      settle();
      compare_all("R1");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule